// File: doc/BRIEF.md
# Transaction mailbox register port

This block is a four-word register mailbox that sits between a local register-bus master and a remote register space. Software running on the local master starts outbound transactions by first loading the payload word and then writing a packed control word. That single control write both fires the transaction and says what it is: a write request, a read request, or a reply to a request from the remote side. Flags in the top nibble give the type and the size, and the low bits give the address. The block keeps one outbound transaction in flight. It tracks an outstanding outbound read until its completion arrives and keeps the returned payload for software to collect.

In the other direction, the block latches one inbound request from the remote side. Software reads the latched payload first and then the latched control word. The control read acknowledges the request and frees the latch for the next one. Status flags take the place of interrupts: software polls them to learn that the port is busy, that a read is outstanding, that a request is waiting, or that a reply is owed. A sticky error flag records a control write that was dropped because the port was busy.

Top module: `msg_regport`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, in_err_o is 0, and word offsets 0, 1, 2 and 3 all read 0.
- R2: A control write (offset 1) made while the port is not busy raises out_valid_o on the next cycle. out_ctrl_o then carries the written word with bits 27 down to ADDR_W forced to 0; bits 31:28 are the flags (31 reply, 30 write, 29 read, 28 half-word) and bits ADDR_W-1:0 are the address. out_data_o carries the last word written to offset 0. Both are held steady until a cycle with out_ready_i high.
- R3: Status (offset 3) bit 4 reads 1 while an outbound transaction waits for its handshake or while an outbound read (control bit 29) waits for its completion. Status bit 0 reads 1 during the read wait only.
- R4: A control write made while status bit 4 is 1 is dropped: out_ctrl_o does not change and no new transaction starts. The dropped write sets status bit 3, which stays set until a status read clears it.
- R5: A cycle with cpl_valid_i high while a read is outstanding stores cpl_data_i, which then reads at offset 2, and clears status bits 0 and 4. A completion that arrives with no read outstanding leaves offset 2 unchanged.
- R6: When no inbound request is held, a cycle with in_valid_i high latches in_data_i and in_ctrl_i. These then read at offsets 0 and 1. Status bit 1 reads 1 and in_ready_o reads 0 until the request is acknowledged. A request offered while one is held is not latched.
- R7: Reading offset 1 acknowledges the held request: status bit 1 clears and in_ready_o returns to 1. Reading offset 0 does not acknowledge it.
- R8: Latching an inbound request whose control bit 29 is set sets status bit 2. Bit 2 clears when a control write carrying bit 31 is accepted as an outbound transaction.
- R9: in_err_o reads 1 while a held inbound request has neither control bit 30 nor bit 29 set.
- R10: Writes to offsets 2 and 3 have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Local register write strobe |
| bus_re_i | input | 1 | Local register read strobe |
| bus_addr_i | input | 2 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as bus_re_i |
| out_valid_o | output | 1 | Outbound transaction offered |
| out_ready_i | input | 1 | Remote accepts the outbound transaction |
| out_ctrl_o | output | 32 | Outbound control word |
| out_data_o | output | 32 | Outbound payload |
| cpl_valid_i | input | 1 | Completion for an outbound read |
| cpl_data_i | input | 32 | Completion payload |
| in_valid_i | input | 1 | Inbound request offered |
| in_ready_o | output | 1 | Inbound latch is free |
| in_ctrl_i | input | 32 | Inbound control word |
| in_data_i | input | 32 | Inbound payload |
| in_err_o | output | 1 | Held inbound request has no read or write flag |

## Verification
Two pairs of events are made to land in the same clock cycle. In the first pair, a read completion arrives in the cycle in which software reads status. The bench drives cpl_valid_i and the status read together. It expects that status read to still show the read as outstanding, and the following status read to show it cleared. In the second pair, a new control write arrives in the cycle in which the pending outbound transaction is handshaken. The port still counts as busy in that cycle, so the bench expects out_valid_o to drop, out_ctrl_o to keep the old word, and the sticky error bit to be set.

// File: rtl/msg_regport_pkg.sv
package msg_regport_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 2;

  localparam logic [OFS_W-1:0] OFS_DATA = 2'd0;
  localparam logic [OFS_W-1:0] OFS_CTRL = 2'd1;
  localparam logic [OFS_W-1:0] OFS_RESP = 2'd2;
  localparam logic [OFS_W-1:0] OFS_STAT = 2'd3;

  // control word flag positions
  localparam int F_REPLY = 31;
  localparam int F_WRITE = 30;
  localparam int F_READ  = 29;
  localparam int F_HALF  = 28;

  // status bit positions
  localparam int S_RDPEND = 0;
  localparam int S_REQ    = 1;
  localparam int S_RESP   = 2;
  localparam int S_ERR    = 3;
  localparam int S_BUSY   = 4;

  // flags kept, reserved bits zeroed, address kept
  function automatic logic [WORD_W-1:0] ctrl_keep_mask(int aw);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i >= F_HALF || i < aw) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/msg_out_slot.sv
module msg_out_slot
  import msg_regport_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_ctrl_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              cpl_valid_i,
  input  logic [WORD_W-1:0] cpl_data_i,
  output logic [WORD_W-1:0] resp_o,
  output logic              rd_pend_o,
  output logic              busy_o
);
  localparam logic [WORD_W-1:0] KEEP = ctrl_keep_mask(ADDR_W);

  logic              valid_q, rd_q;
  logic [WORD_W-1:0] ctrl_q, data_q, resp_q;
  logic              accept;

  assign busy_o = valid_q || rd_q;
  assign accept = launch_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ctrl_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      ctrl_q  <= ctrl_i & KEEP;
      data_q  <= data_i;
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      resp_q <= '0;
    end else if (accept && ctrl_i[F_READ]) begin
      rd_q <= 1'b1;
    end else if (rd_q && cpl_valid_i) begin
      rd_q   <= 1'b0;
      resp_q <= cpl_data_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_ctrl_o  = ctrl_q;
  assign out_data_o  = data_q;
  assign resp_o      = resp_q;
  assign rd_pend_o   = rd_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_ctrl_o) && $stable(out_data_o));
  a_r4_reject_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && busy_o |=> $stable(out_ctrl_o));
  a_r5_cpl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_o && cpl_valid_i |=> !rd_pend_o);
  a_r5_no_stray_cpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_pend_o |=> $stable(resp_o));
endmodule

// File: rtl/msg_in_latch.sv
module msg_in_latch
  import msg_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_ctrl_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              ack_i,
  input  logic              reply_sent_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] data_o,
  output logic              req_o,
  output logic              resp_pend_o,
  output logic              err_o
);
  logic              req_q, resp_q;
  logic [WORD_W-1:0] ctrl_q, data_q;
  logic              accept;

  assign in_ready_o = !req_q;
  assign accept     = in_valid_i && !req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ctrl_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      req_q  <= 1'b1;
      ctrl_q <= in_ctrl_i;
      data_q <= in_data_i;
    end else if (ack_i && req_q) begin
      req_q <= 1'b0;
    end
  end

  // a newly latched read outranks a reply sent in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          resp_q <= 1'b0;
    else if (accept && in_ctrl_i[F_READ]) resp_q <= 1'b1;
    else if (reply_sent_i)                resp_q <= 1'b0;
  end

  assign ctrl_o      = ctrl_q;
  assign data_o      = data_q;
  assign req_o       = req_q;
  assign resp_pend_o = resp_q;
  assign err_o       = req_q && !ctrl_q[F_WRITE] && !ctrl_q[F_READ];

  a_r6_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(ctrl_o) && $stable(data_o));
  a_r7_ack_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> in_ready_o);
endmodule

// File: rtl/msg_status_reg.sv
module msg_status_reg
  import msg_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_pend_i,
  input  logic              req_i,
  input  logic              resp_pend_i,
  input  logic              busy_i,
  input  logic              reject_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] status_o
);
  logic err_q;

  // a drop in the same cycle as the clearing read keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (reject_i) err_q <= 1'b1;
    else if (clr_i)    err_q <= 1'b0;
  end

  always_comb begin
    status_o           = '0;
    status_o[S_RDPEND] = rd_pend_i;
    status_o[S_REQ]    = req_i;
    status_o[S_RESP]   = resp_pend_i;
    status_o[S_ERR]    = err_q;
    status_o[S_BUSY]   = busy_i;
  end

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[S_ERR] && !clr_i |=> status_o[S_ERR]);
  a_r3_rdpend_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_i |-> busy_i);
endmodule

// File: rtl/msg_regport.sv
module msg_regport
  import msg_regport_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [OFS_W-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_ctrl_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              cpl_valid_i,
  input  logic [WORD_W-1:0] cpl_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_ctrl_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_err_o
);
  logic [WORD_W-1:0] data_q;
  logic              ctrl_we, busy, rd_pend, req, resp_pend;
  logic              ack, clr, reject, reply_sent;
  logic [WORD_W-1:0] resp_w, in_ctrl_w, in_data_w, status_w;

  assign ctrl_we    = bus_we_i && (bus_addr_i == OFS_CTRL);
  assign reject     = ctrl_we && busy;
  assign reply_sent = ctrl_we && !busy && bus_wdata_i[F_REPLY];
  assign ack        = bus_re_i && (bus_addr_i == OFS_CTRL);
  assign clr        = bus_re_i && (bus_addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    data_q <= '0;
    else if (bus_we_i && bus_addr_i == OFS_DATA)    data_q <= bus_wdata_i;
  end

  msg_out_slot #(.ADDR_W(ADDR_W)) u_out (
    .clk_i, .rst_ni,
    .launch_i   (ctrl_we),
    .ctrl_i     (bus_wdata_i),
    .data_i     (data_q),
    .out_valid_o, .out_ready_i, .out_ctrl_o, .out_data_o,
    .cpl_valid_i, .cpl_data_i,
    .resp_o     (resp_w),
    .rd_pend_o  (rd_pend),
    .busy_o     (busy)
  );

  msg_in_latch u_in (
    .clk_i, .rst_ni,
    .in_valid_i, .in_ready_o, .in_ctrl_i, .in_data_i,
    .ack_i        (ack),
    .reply_sent_i (reply_sent),
    .ctrl_o       (in_ctrl_w),
    .data_o       (in_data_w),
    .req_o        (req),
    .resp_pend_o  (resp_pend),
    .err_o        (in_err_o)
  );

  msg_status_reg u_stat (
    .clk_i, .rst_ni,
    .rd_pend_i   (rd_pend),
    .req_i       (req),
    .resp_pend_i (resp_pend),
    .busy_i      (busy),
    .reject_i    (reject),
    .clr_i       (clr),
    .status_o    (status_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      unique case (bus_addr_i)
        OFS_DATA: bus_rdata_o = in_data_w;
        OFS_CTRL: bus_rdata_o = in_ctrl_w;
        OFS_RESP: bus_rdata_o = resp_w;
        default:  bus_rdata_o = status_w;
      endcase
    end
  end

  a_r4_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && busy |=> status_w[S_ERR]);
  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && !busy |=> out_valid_o && status_w[S_BUSY]);
  a_r8_reply_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_sent && !in_valid_i |=> !status_w[S_RESP]);
endmodule

// File: tb/msg_regport_bench.sv
module msg_regport_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_we = 0, bus_re = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        out_valid, out_ready = 0;
  logic [31:0] out_ctrl, out_data;
  logic        cpl_valid = 0;
  logic [31:0] cpl_data = 0;
  logic        in_valid = 0, in_ready, in_err;
  logic [31:0] in_ctrl = 0, in_data = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msg_regport u_msg_regport (
    .clk_i(clk), .rst_ni,
    .bus_we_i(bus_we), .bus_re_i(bus_re), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_ctrl_o(out_ctrl), .out_data_o(out_data),
    .cpl_valid_i(cpl_valid), .cpl_data_i(cpl_data),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_ctrl_i(in_ctrl), .in_data_i(in_data), .in_err_o(in_err)
  );

  // {data, control written, control expected on out_ctrl_o}
  localparam logic [95:0] VEC [4] = '{
    {32'hDEAD_BEEF, 32'h4000_1234, 32'h4000_1234},
    {32'h0000_5678, 32'h5FF0_0204, 32'h5000_0204},
    {32'hA5A5_0F0F, 32'h2000_0200, 32'h2000_0200},
    {32'h7AD0_5678, 32'h8000_0000, 32'h8000_0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [31:0] v);
    bus_re = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic handshake();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic complete(logic [31:0] d);
    cpl_valid = 1; cpl_data = d;
    @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic offer(logic [31:0] c, logic [31:0] d);
    in_valid = 1; in_ctrl = c; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 in_err", {31'd0, in_err}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(a[1:0], v);
      chk("R1 offset read", v, 32'd0);
    end

    // R2/R3/R5 vector walk
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d, c, e;
      d = VEC[i][95:64]; c = VEC[i][63:32]; e = VEC[i][31:0];
      bus_wr(2'd0, d);
      bus_wr(2'd1, c);
      chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R2 out_ctrl", out_ctrl, e);
      chk("R2 out_data", out_data, d);
      bus_rd(2'd3, v);
      chk("R3 status launched", v, c[29] ? 32'h11 : 32'h10);
      chk("R2 held", out_ctrl, e);
      handshake();
      chk("R2 out_valid dropped", {31'd0, out_valid}, 32'd0);
      if (c[29]) begin
        bus_rd(2'd3, v);
        chk("R3 read wait", v, 32'h11);
        complete(~d);
        bus_rd(2'd2, v);
        chk("R5 response", v, ~d);
      end
      bus_rd(2'd3, v);
      chk("R3 idle status", v, 32'h0);
    end

    // R5 stray completion ignored
    complete(32'h1111_1111);
    bus_rd(2'd2, v);
    chk("R5 stray completion", v, ~32'hA5A5_0F0F);

    // R4 dropped write while busy
    bus_wr(2'd1, 32'h2000_0010);
    bus_wr(2'd1, 32'h4000_0099);
    chk("R4 ctrl unchanged", out_ctrl, 32'h2000_0010);
    bus_rd(2'd3, v);
    chk("R4 err set", v, 32'h19);
    bus_rd(2'd3, v);
    chk("R4 err cleared by read", v, 32'h11);
    handshake();
    bus_wr(2'd1, 32'h4000_0077);
    chk("R4 no launch during read wait", {31'd0, out_valid}, 32'd0);
    // same cycle: completion and status read
    cpl_valid = 1; cpl_data = 32'h0BAD_F00D;
    bus_rd(2'd3, v);
    cpl_valid = 0;
    chk("R5 status during completion", v, 32'h19);
    bus_rd(2'd3, v);
    chk("R5 status after completion", v, 32'h0);
    bus_rd(2'd2, v);
    chk("R5 completion data", v, 32'h0BAD_F00D);

    // same cycle: control write and outbound handshake
    bus_wr(2'd1, 32'h4000_0001);
    out_ready = 1;
    bus_wr(2'd1, 32'h4000_0002);
    out_ready = 0;
    chk("R4 handshake drops valid", {31'd0, out_valid}, 32'd0);
    chk("R4 ctrl kept", out_ctrl, 32'h4000_0001);
    bus_rd(2'd3, v);
    chk("R4 err on handshake cycle", v, 32'h08);

    // R6/R7 inbound write request
    offer(32'h4000_0ABC, 32'h1234_5678);
    chk("R6 in_ready low", {31'd0, in_ready}, 32'd0);
    bus_rd(2'd3, v);
    chk("R6 status req", v, 32'h02);
    bus_rd(2'd0, v);
    chk("R6 data latched", v, 32'h1234_5678);
    bus_rd(2'd3, v);
    chk("R7 data read no ack", v, 32'h02);
    offer(32'h2000_0001, 32'h9999_9999);
    bus_rd(2'd0, v);
    chk("R6 second offer not latched", v, 32'h1234_5678);
    chk("R9 no err on write req", {31'd0, in_err}, 32'd0);
    bus_rd(2'd1, v);
    chk("R6 ctrl latched", v, 32'h4000_0ABC);
    chk("R7 in_ready after ack", {31'd0, in_ready}, 32'd1);
    bus_rd(2'd3, v);
    chk("R7 status after ack", v, 32'h0);

    // R8 inbound read and reply
    offer(32'h2000_0040, 32'h0);
    bus_rd(2'd3, v);
    chk("R8 resp pending", v, 32'h06);
    bus_rd(2'd1, v);
    bus_rd(2'd3, v);
    chk("R8 resp pending after ack", v, 32'h04);
    bus_wr(2'd0, 32'hCAFE_0001);
    bus_wr(2'd1, 32'h8000_0000);
    chk("R8 reply ctrl", out_ctrl, 32'h8000_0000);
    chk("R8 reply data", out_data, 32'hCAFE_0001);
    bus_rd(2'd3, v);
    chk("R8 resp cleared", v, 32'h10);
    handshake();

    // R9 request with no type flag
    offer(32'h1000_0005, 32'h55);
    chk("R9 err type", {31'd0, in_err}, 32'd1);
    bus_rd(2'd1, v);
    chk("R9 err cleared on ack", {31'd0, in_err}, 32'd0);

    // R10 writes to response and status ignored
    bus_wr(2'd2, 32'hFFFF_FFFF);
    bus_rd(2'd2, v);
    chk("R10 response untouched", v, 32'h0BAD_F00D);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_rd(2'd3, v);
    chk("R10 status untouched", v, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule